// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter

This block raises an interrupt after a programmed number of video scanlines. The CPU programs it through four write targets. Each target is chosen by the top three address bits and address bit 0, and the rest of the address is ignored. An external single-cycle strobe marks each scanline. The block holds an 8-bit reload value, a signed down-counter one bit wider than that value, an enable flag and a level interrupt output.

The counter counts down once per strobe while it is zero or positive. When it steps from zero to minus one with the enable set, the interrupt goes high. It stays high until software writes the disable target. A negative counter stays where it is until software loads it again.

Two pieces of state decide whether a write loads the counter. The first is a pending flag, set by a reload-value write. The second is a direct-load mode, entered by a disable write and left at the next strobe. In direct-load mode a reload-value write goes straight into the counter and clears the pending flag. An enable write copies the reload value into the counter only while the pending flag is set.

Top module: `scanline_irq_counter`

## Requirements
- R1: A write acts only when `wr_en` is high and the address ANDed with 0xE001 equals 0xC000 (store reload value), 0xC001 (copy reload value to counter), 0xE000 (disable) or 0xE001 (enable). Mirrored addresses such as 0xDFFE and 0xFFFF therefore act, and writes at 0x8000 to 0xBFFF have no effect.
- R2: A store-reload-value write outside direct-load mode keeps the value and sets the pending flag. It leaves the counter unchanged.
- R3: A copy write loads the counter with the stored reload value, whatever the pending flag holds.
- R4: A disable write clears the enable flag, drops the interrupt in the next cycle and enters direct-load mode.
- R5: In direct-load mode, a store-reload-value write also loads the counter with the written value and clears the pending flag.
- R6: An enable write sets the enable flag. It reloads the counter from the stored value only when the pending flag is set.
- R7: Each strobe leaves direct-load mode. It decrements the counter by one when the counter is zero or positive.
- R8: A strobe that takes the counter from 0 to -1 while enabled sets the interrupt, and the interrupt stays set until a disable write. With the enable clear, the same step does not set the interrupt.
- R9: A negative counter keeps its value across strobes until a write loads it.
- R10: After reset the interrupt is low, and the counter, reload value, enable, pending flag and direct-load mode are all zero.
- R11: When a write loads the counter in the same cycle as a strobe, the counter takes the written value and the strobe neither decrements it nor causes an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| line_tick | input | 1 | One-cycle pulse per scanline |
| irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that `line_tick` and `wr_en` are clean single-cycle pulses synchronous to `clk`. They also assume that `wr_addr` and `wr_data` are valid whenever `wr_en` is high. The stimulus drives every write and strobe for exactly one clock and changes inputs only on the falling edge. The counter is never visible at the ports, so each counter value is inferred from which strobe raises the interrupt. Every sequence is therefore laid out so that a wrong load, a missed load or a stray decrement moves the edge of `irq` to a different strobe.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_LATCH,
    CMD_RELOAD,
    CMD_OFF,
    CMD_ON
  } sirq_cmd_e;

  localparam logic [2:0] SEL_LATCH_GRP  = 3'b110;
  localparam logic [2:0] SEL_ENABLE_GRP = 3'b111;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/sirq_decode.sv
module sirq_decode
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output sirq_cmd_e         cmd
);
  localparam int TOP = ADDR_W - 1;

  logic [2:0] grp;
  logic       unused_addr;

  assign grp         = wr_addr[TOP -: 3];
  assign unused_addr = ^wr_addr[TOP-3:1];

  always_comb begin
    cmd = CMD_NONE;
    if (wr_en) begin
      if (grp == SEL_LATCH_GRP)       cmd = wr_addr[0] ? CMD_RELOAD : CMD_LATCH;
      else if (grp == SEL_ENABLE_GRP) cmd = wr_addr[0] ? CMD_ON : CMD_OFF;
    end
  end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sirq_cmd_e         cmd,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              en_q,
  output logic              load,
  output logic [DATA_W-1:0] load_val
);
  logic [DATA_W-1:0] latch_q, latch_d;
  logic              pend_q, pend_d;
  logic              rmode_q, rmode_d;
  logic              en_d;
  logic              upd;

  assign upd = line_tick || (cmd != CMD_NONE);

  always_comb begin
    latch_d  = latch_q;
    pend_d   = pend_q;
    rmode_d  = rmode_q;
    en_d     = en_q;
    load     = 1'b0;
    load_val = wr_data;
    if (line_tick) rmode_d = 1'b0;
    case (cmd)
      CMD_LATCH: begin
        latch_d = wr_data;
        if (rmode_q) begin
          load   = 1'b1;
          pend_d = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end
      CMD_RELOAD: begin
        load     = 1'b1;
        load_val = latch_q;
      end
      CMD_OFF: begin
        en_d    = 1'b0;
        rmode_d = 1'b1;
      end
      CMD_ON: begin
        en_d = 1'b1;
        if (pend_q) begin
          load     = 1'b1;
          load_val = latch_q;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      pend_q  <= 1'b0;
      rmode_q <= 1'b0;
      en_q    <= 1'b0;
    end else if (upd) begin
      latch_q <= latch_d;
      pend_q  <= pend_d;
      rmode_q <= rmode_d;
      en_q    <= en_d;
    end
  end

  // R4: disable enters direct-load mode with enable cleared
  a_r4_off_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_OFF) |=> (rmode_q && !en_q));
  // R7: a strobe leaves direct-load mode unless a disable lands with it
  a_r7_tick_leaves_rmode: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && cmd != CMD_OFF) |=> !rmode_q);
  // R6: enable write sets the flag
  a_r6_on_sets_en: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ON) |=> en_q);
  // R5: a direct load leaves no pending reload behind
  a_r5_direct_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LATCH && rmode_q) |=> !pend_q);
endmodule

// File: rtl/sirq_counter.sv
module sirq_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              tick,
  input  logic              en_q,
  input  logic              clr,
  output logic              irq_q
);
  localparam int CNT_W = DATA_W + 1;
  localparam logic signed [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic signed [CNT_W-1:0] ZERO = '0;

  logic signed [CNT_W-1:0] cnt_q, cnt_d;
  logic                    irq_d;
  logic                    neg;
  logic                    undr;

  assign neg  = cnt_q[CNT_W-1];
  assign undr = tick && !load && (cnt_q == ZERO);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = $signed({1'b0, load_val});
    else if (tick && !neg) cnt_d = cnt_q - ONE;
  end

  always_comb begin
    irq_d = irq_q;
    if (clr)               irq_d = 1'b0;
    else if (undr && en_q) irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load || tick) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  // R9: a negative count is frozen without a load
  a_r9_hold_negative: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && neg) |=> $stable(cnt_q));
  // R7: a strobe on a non-negative count steps it down by one
  a_r7_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !neg) |=> (cnt_q == $past(cnt_q) - ONE));
  // R11: a load wins over a same-cycle strobe
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $signed({1'b0, $past(load_val)})));
  // R4: disable drops the interrupt
  a_r4_clr_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq_q);
  // R8: the interrupt only rises on an enabled strobe
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_q && !(tick && en_q)) |=> !irq_q);
endmodule

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter
  import sirq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              line_tick,
  output logic              irq
);
  logic              rst_n_s;
  sirq_cmd_e         cmd;
  logic              en_w;
  logic              load_w;
  logic [DATA_W-1:0] load_val_w;
  logic              off_w;

  sirq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  sirq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .cmd     (cmd)
  );

  assign off_w = (cmd == CMD_OFF);

  sirq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cmd       (cmd),
    .wr_data   (wr_data),
    .line_tick (line_tick),
    .en_q      (en_w),
    .load      (load_w),
    .load_val  (load_val_w)
  );

  sirq_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load_w),
    .load_val (load_val_w),
    .tick     (line_tick),
    .en_q     (en_w),
    .clr      (off_w),
    .irq_q    (irq)
  );
endmodule

// File: tb/tb_scanline_irq_counter.sv
`timescale 1ns/1ps
module tb_scanline_irq_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  scanline_irq_counter dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_tick(line_tick), .irq(irq)
  );

  task automatic check(input logic act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: one-cycle operation, expected irq after the edge goes to the scoreboard
  task automatic op(input bit w, input logic [15:0] a, input logic [7:0] d,
                    input bit tk, input bit exp, input string tag);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; line_tick = tk;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    wr_en = 1'b0; line_tick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit exp, input string tag);
    op(1'b1, a, d, 1'b0, exp, tag);
  endtask

  task automatic tk(input bit exp, input string tag);
    op(1'b0, 16'h0000, 8'h00, 1'b1, exp, tag);
  endtask

  // monitor: pops one expectation per active edge and compares after it
  bit    mon_e;
  string mon_t;
  always @(posedge clk) begin
    if (rst_n && (wr_en || line_tick) && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      #2 check(irq, mon_e, mon_t);
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(irq, 1'b0, "R10 irq low in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(irq, 1'b0, "R10 irq low after reset");

    // R10: counter starts at 0, enable without pending does not reload
    wr(16'hE001, 8'h00, 1'b0, "R6 enable, nothing pending");
    tk(1'b1, "R10 counter was zero");
    tk(1'b1, "R8 irq stays high");
    wr(16'hE000, 8'h00, 1'b0, "R4 disable drops irq");

    // R7: strobe ends direct-load mode, then a store only sets pending
    tk(1'b0, "R7 strobe while disabled");
    wr(16'hC000, 8'h02, 1'b0, "R2 store outside direct mode");
    for (int i = 0; i < 3; i++) tk(1'b0, "R9 negative count held");
    wr(16'hE001, 8'h00, 1'b0, "R6 enable reloads pending value");
    tk(1'b0, "R7 count 1");
    tk(1'b0, "R7 count 0");
    tk(1'b1, "R8 underflow raises irq");
    tk(1'b1, "R8 irq held");
    wr(16'hE000, 8'h00, 1'b0, "R4 disable drops irq");

    // R5: direct load clears pending
    wr(16'hC000, 8'h01, 1'b0, "R5 direct load");
    tk(1'b0, "R5 count 0 disabled");
    wr(16'hE001, 8'h00, 1'b0, "R5 enable without reload");
    tk(1'b1, "R5 pending was cleared");
    wr(16'hE000, 8'h00, 1'b0, "R4 disable");

    // R1: decode, mirrors and ignored addresses
    tk(1'b0, "R7 leave direct mode");
    wr(16'hC000, 8'h05, 1'b0, "R2 store 5");
    wr(16'hFFFF, 8'h00, 1'b0, "R1 mirrored enable");
    wr(16'h8000, 8'h00, 1'b0, "R1 ignored 0x8000");
    wr(16'hA000, 8'hFF, 1'b0, "R1 ignored 0xA000");
    wr(16'hA001, 8'hFF, 1'b0, "R1 ignored 0xA001");
    wr(16'hBFFF, 8'h00, 1'b0, "R1 ignored 0xBFFF");
    wr(16'hDFFE, 8'h01, 1'b0, "R2 mirrored store leaves counter");
    for (int i = 0; i < 5; i++) tk(1'b0, "R1 counting from 5");
    tk(1'b1, "R1 underflow after six strobes");
    wr(16'hC001, 8'h00, 1'b1, "R8 copy write keeps irq");
    wr(16'hE000, 8'h00, 1'b0, "R4 disable");

    // R3 and R8: copy write alone, underflow while disabled
    wr(16'hC000, 8'h02, 1'b0, "R5 direct load 2");
    tk(1'b0, "R7 count 1");
    tk(1'b0, "R7 count 0");
    tk(1'b0, "R8 underflow while disabled is silent");
    wr(16'hE001, 8'h00, 1'b0, "R6 enable, nothing pending");
    tk(1'b0, "R9 negative count held while enabled");
    wr(16'hC001, 8'h00, 1'b0, "R3 copy reload value");
    tk(1'b0, "R3 count 1");
    tk(1'b0, "R3 count 0");
    tk(1'b1, "R3 underflow after reload");
    wr(16'hE000, 8'h00, 1'b0, "R4 disable");

    // R11: write beats a same-cycle strobe
    tk(1'b0, "R7 leave direct mode");
    wr(16'hC000, 8'h04, 1'b0, "R2 store 4");
    wr(16'hE001, 8'h00, 1'b0, "R6 enable reloads 4");
    for (int i = 0; i < 3; i++) tk(1'b0, "R7 counting from 4");
    op(1'b1, 16'hC001, 8'h00, 1'b1, 1'b0, "R11 copy with strobe");
    for (int i = 0; i < 4; i++) tk(1'b0, "R11 counter holds written value");
    tk(1'b1, "R11 underflow after five strobes");
    wr(16'hE000, 8'h00, 1'b0, "R4 final disable");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule